// File: doc/BRIEF.md
# Configuration Access Address Router

This block turns a configuration read or write, named by bus, device, function and register offset, into a short sequence of 32-bit accesses on a simple register bus. Bus 0 names the root port itself: its registers are reached by writing the masked offset into an index register and then accessing the matching data window. Any other bus names a downstream device: a packed address word is written into a second index register, and the data access then goes to that path's own data window.

Some targets cannot be reached. On bus 0 only device 0 exists. On other buses only functions 0 and 1 are reachable. A request for any other target never reaches the register bus. It completes at once with an error flag. The block handles one request at a time. The request port takes a new request only after the response to the previous one has been accepted.

Top module: `cfgacc_router`

## Requirements
- R1: A bus-0, device-0 request writes (offset AND 0x1FFC) to address 0x120. Its 32-bit data access then goes to address 0x124.
- R2: A bus-0 request with device number 1 or above makes no register-bus access and completes with rsp_err = 1.
- R3: For a nonzero bus, the index word is built as follows: bus in bits 27:20, device in 19:15, function in 14:12, offset bits 11:2 in bits 11:2, the value 01 in bits 1:0, and zero in bits 31:28.
- R4: For a nonzero bus, the index word is written to address 0x1F8. The data access then goes to address 0x1FC.
- R5: A nonzero-bus request with function 2 to 7 makes no register-bus access and completes with rsp_err = 1. Functions 0 and 1 are accepted.
- R6: A rejected read returns rsp_rdata = 0xFFFFFFFF. A rejected write returns rsp_rdata = 0. Both have rsp_err = 1.
- R7: The index write finishes its handshake (rb_valid and rb_ready both high) before the data access is presented. A pending access holds its address, data and direction until rb_ready is seen.
- R8: req_ready is high only when no request is in flight. A pending response holds its value until rsp_ready is seen.
- R9: A successful read returns the data seen on rb_rdata during the data handshake, with rsp_err = 0. A successful write carries req_wdata on the data access and returns rsp_rdata = 0 with rsp_err = 0.
- R10: During and just after reset, req_ready = 1, rb_valid = 0 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 13 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rb_valid | output | 1 | Register-bus access pending |
| rb_ready | input | 1 | Register-bus access completes this cycle |
| rb_write | output | 1 | Register-bus direction |
| rb_addr | output | 12 | Register-bus byte address |
| rb_wdata | output | 32 | Register-bus write data |
| rb_rdata | input | 32 | Register-bus read data, sampled at handshake |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_rdata | output | 32 | Read data or fill value |
| rsp_err | output | 1 | Target was unreachable |

## Verification
The hardest case to reach is an access whose index write and data access are each stalled by rb_ready for an uneven number of cycles, while the following request is already waiting at the port. The bench drives rb_ready and rsp_ready from a shift-register pattern during a second pass over the same request set. This stretches both phases and the response hold by different amounts. A rejected request placed between two accepted ones must then produce no bus traffic. This case also tests that the busy window ends exactly when the response handshake completes.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_RESP
    } phase_e;
endpackage

// File: rtl/cfgacc_decode.sv
module cfgacc_decode #(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int OFF_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    output logic              is_root,
    output logic              reject,
    output logic [DATA_W-1:0] word
);
    // bit positions of the packed downstream index word
    localparam int FN_LSB  = 12;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam logic [OFF_W-1:0] ROOT_MASK = OFF_W'('h1FFC);
    localparam logic [FN_W-1:0]  FN_LIMIT  = FN_W'(1);

    assign is_root = (bus == '0);
    assign reject  = is_root ? (dev != '0) : (fn > FN_LIMIT);

    always_comb begin
        word = '0;
        if (is_root) begin
            word[OFF_W-1:0] = off & ROOT_MASK;
        end else begin
            word[BUS_LSB +: BUS_W] = bus;
            word[DEV_LSB +: DEV_W] = dev;
            word[FN_LSB +: FN_W]   = fn;
            word[11:2]             = off[11:2];
            word[1:0]              = 2'b01;
        end
    end
endmodule

// File: rtl/cfgacc_seq.sv
module cfgacc_seq
    import cfgacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RB_AW  = 12,
    parameter int ROOT_IDX = 'h120,
    parameter int ROOT_DAT = 'h124,
    parameter int DN_IDX   = 'h1F8,
    parameter int DN_DAT   = 'h1FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dec_root,
    input  logic              dec_reject,
    input  logic [DATA_W-1:0] dec_word,
    output logic              rb_valid,
    input  logic              rb_ready,
    output logic              rb_write,
    output logic [RB_AW-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam logic [RB_AW-1:0] A_RI = RB_AW'(ROOT_IDX);
    localparam logic [RB_AW-1:0] A_RD = RB_AW'(ROOT_DAT);
    localparam logic [RB_AW-1:0] A_DI = RB_AW'(DN_IDX);
    localparam logic [RB_AW-1:0] A_DD = RB_AW'(DN_DAT);

    typedef struct packed {
        phase_e            phase;
        logic              wr;
        logic              err;
        logic [RB_AW-1:0]  idx_addr;
        logic [RB_AW-1:0]  dat_addr;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.wr       = req_write;
                    st_d.wdata    = req_wdata;
                    st_d.word     = dec_word;
                    st_d.idx_addr = dec_root ? A_RI : A_DI;
                    st_d.dat_addr = dec_root ? A_RD : A_DD;
                    if (dec_reject) begin
                        st_d.err   = 1'b1;
                        st_d.rdata = req_write ? '0 : '1;
                        st_d.phase = PH_RESP;
                    end else begin
                        st_d.err   = 1'b0;
                        st_d.rdata = '0;
                        st_d.phase = PH_ADDR;
                    end
                end
            end
            PH_ADDR: begin
                if (rb_ready) st_d.phase = PH_DATA;
            end
            PH_DATA: begin
                if (rb_ready) begin
                    st_d.rdata = st_q.wr ? '0 : rb_rdata;
                    st_d.phase = PH_RESP;
                end
            end
            default: begin
                if (rsp_ready) st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, wr: 1'b0, err: 1'b0, idx_addr: '0,
                      dat_addr: '0, word: '0, wdata: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign rb_valid  = (st_q.phase == PH_ADDR) || (st_q.phase == PH_DATA);
    assign rb_write  = (st_q.phase == PH_ADDR) ? 1'b1 : st_q.wr;
    assign rb_addr   = (st_q.phase == PH_ADDR) ? st_q.idx_addr : st_q.dat_addr;
    assign rb_wdata  = (st_q.phase == PH_ADDR) ? st_q.word : st_q.wdata;
    assign rsp_valid = (st_q.phase == PH_RESP);
    assign rsp_rdata = st_q.rdata;
    assign rsp_err   = st_q.err;

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid && !rb_ready |=> rb_valid && $stable(rb_addr) && $stable(rb_wdata) && $stable(rb_write)); // R7
    AST_INDEX_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid && rb_ready && (rb_addr == A_RI || rb_addr == A_DI)
        |=> rb_valid && (rb_addr == A_RD || rb_addr == A_DD)); // R7
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R8
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && dec_reject |=> rsp_valid && rsp_err && !rb_valid); // R6
endmodule

// File: rtl/cfgacc_router.sv
module cfgacc_router #(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int OFF_W  = 13,
    parameter int DATA_W = 32,
    parameter int RB_AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rb_valid,
    input  logic              rb_ready,
    output logic              rb_write,
    output logic [RB_AW-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int ROOT_IDX = 'h120;
    localparam int ROOT_DAT = 'h124;
    localparam int DN_IDX   = 'h1F8;
    localparam int DN_DAT   = 'h1FC;

    logic              dec_root;
    logic              dec_reject;
    logic [DATA_W-1:0] dec_word;

    cfgacc_decode #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) u_dec (
        .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
        .is_root(dec_root), .reject(dec_reject), .word(dec_word)
    );

    cfgacc_seq #(
        .DATA_W(DATA_W), .RB_AW(RB_AW),
        .ROOT_IDX(ROOT_IDX), .ROOT_DAT(ROOT_DAT), .DN_IDX(DN_IDX), .DN_DAT(DN_DAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wdata(req_wdata),
        .dec_root(dec_root), .dec_reject(dec_reject), .dec_word(dec_word),
        .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_write(rb_write),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    AST_ROOT_INDEX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid && rb_addr == RB_AW'(ROOT_IDX)
        |-> rb_write && ((rb_wdata & ~DATA_W'('h1FFC)) == '0)); // R1
    AST_DN_INDEX_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid && rb_addr == RB_AW'(DN_IDX)
        |-> rb_write && rb_wdata[1:0] == 2'b01 && rb_wdata[31:28] == 4'h0); // R3
endmodule

// File: tb/cfgacc_router_test.sv
`timescale 1ns/1ps
module cfgacc_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [12:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rb_valid, rb_write;
    logic        rb_ready = 1'b1;
    logic [11:0] rb_addr;
    logic [31:0] rb_wdata, rb_rdata;
    logic        rsp_valid, rsp_err;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit busy = 0;
    bit stall = 0;
    logic [7:0]  lfsr = 8'hA7;
    logic [31:0] last_word = '0;

    int unsigned q_addr[$];
    int unsigned q_data[$];
    bit          q_wr[$];
    string       q_tag[$];
    int unsigned r_data[$];
    bit          r_err[$];
    string       r_tag[$];

    always #2.5 clk = ~clk;

    cfgacc_router uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_wdata(req_wdata),
        .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_write(rb_write),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    // simple register-bus slave: reads return the inverse of the last index word
    assign rb_rdata = ~last_word;
    always @(posedge clk)
        if (rb_valid && rb_ready && rb_write && (rb_addr == 12'h120 || rb_addr == 12'h1F8))
            last_word <= rb_wdata;

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rb_ready  = stall ? lfsr[0] : 1'b1;
        rsp_ready = stall ? lfsr[4] : 1'b1;
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // reference model, evaluated once per cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == !busy, "R8", "req_ready vs busy", 32'(req_ready), 32'(!busy));
            if (rb_valid && rb_ready) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R2", "bus access with none expected (R5)", 32'(rb_addr), 0);
                end else begin
                    automatic int unsigned ea = q_addr.pop_front();
                    automatic int unsigned ed = q_data.pop_front();
                    automatic bit ew = q_wr.pop_front();
                    automatic string et = q_tag.pop_front();
                    chk(32'(rb_addr) == ea, et, "bus address", 32'(rb_addr), ea);
                    chk(rb_write == ew, et, "bus direction", 32'(rb_write), 32'(ew));
                    if (ew) chk(rb_wdata == ed, et, "bus write data", rb_wdata, ed);
                end
            end
            if (rsp_valid && rsp_ready) begin
                if (r_data.size() == 0) begin
                    chk(0, "R8", "response with none expected", rsp_rdata, 0);
                end else begin
                    automatic int unsigned xd = r_data.pop_front();
                    automatic bit xe = r_err.pop_front();
                    automatic string xt = r_tag.pop_front();
                    chk(rsp_rdata == xd, xt, "response data", rsp_rdata, xd);
                    chk(rsp_err == xe, xt, "response error", 32'(rsp_err), 32'(xe));
                end
                busy = 0;
            end
            if (req_valid && req_ready) begin
                automatic int unsigned w;
                automatic bit root = (req_bus == 0);
                automatic bit rej = root ? (req_dev != 0) : (req_fn > 1);
                busy = 1;
                if (root) w = int'(req_off) & 32'h1FFC;
                else w = (int'(req_bus) << 20) | (int'(req_dev) << 15) | (int'(req_fn) << 12)
                         | (int'(req_off) & 32'hFFC) | 1;
                if (rej) begin
                    r_data.push_back(req_write ? 32'h0 : 32'hFFFF_FFFF);
                    r_err.push_back(1'b1);
                    r_tag.push_back(root ? "R2 R6" : "R5 R6");
                end else begin
                    q_addr.push_back(root ? 32'h120 : 32'h1F8);
                    q_data.push_back(w);
                    q_wr.push_back(1'b1);
                    q_tag.push_back(root ? "R1 R7" : "R3 R4 R7");
                    q_addr.push_back(root ? 32'h124 : 32'h1FC);
                    q_data.push_back(req_wdata);
                    q_wr.push_back(req_write);
                    q_tag.push_back(root ? "R1 R9" : "R4 R9");
                    r_data.push_back(req_write ? 32'h0 : ~w);
                    r_err.push_back(1'b0);
                    r_tag.push_back("R9");
                end
            end
        end
    end

    task automatic send(bit wr, int b, int d, int f, int o, logic [31:0] wd);
        @(posedge clk); #1;
        req_write = wr; req_bus = 8'(b); req_dev = 5'(d); req_fn = 3'(f);
        req_off = 13'(o); req_wdata = wd; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic run_set();
        send(0, 0, 0, 0, 'h03C, 32'h0);
        send(1, 0, 0, 0, 'h1FFF, 32'h1234_5678);
        send(0, 0, 1, 0, 'h010, 32'h0);
        send(1, 0, 31, 7, 'h010, 32'hDEAD_BEEF);
        send(0, 1, 0, 0, 'h010, 32'h0);
        send(1, 255, 31, 1, 'h1FFF, 32'hCAFE_F00D);
        send(0, 3, 4, 2, 'h020, 32'h0);
        send(1, 7, 2, 7, 'h020, 32'h5555_AAAA);
        send(0, 128, 16, 1, 'h0A6, 32'h0);
        send(1, 0, 0, 5, 'h1000, 32'h0BAD_C0DE);
        while (busy || req_valid) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready in reset", 32'(req_ready), 1);
        chk(rb_valid == 1'b0, "R10", "rb_valid in reset", 32'(rb_valid), 0);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rb_valid && !rsp_valid, "R10", "idle after reset",
            {29'b0, req_ready, rb_valid, rsp_valid}, 32'h4);
        run_set();
        stall = 1'b1;
        run_set();
        stall = 1'b0;
        repeat (4) @(negedge clk);
        chk(q_addr.size() == 0, "R7", "bus ops left over", 32'(q_addr.size()), 0);
        chk(r_data.size() == 0, "R8", "responses left over", 32'(r_data.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule